// File: doc/BRIEF.md
# Debug CPU Stall and Reset Control Register

This block is the processor-control leaf of an on-chip debug unit. While the debug chain has selected it, a host shifts serial frames into it one bit per clock and reads a response back on the same serial line. A frame can either write a wide control word or read the live control state back. Two bits of that word are live. One drives the processor's stall input and the other drives its reset input. Every request and every response is protected by a CRC-32. A write whose CRC or reserved bits are wrong leaves the register untouched and reports a non-zero status.

A frame starts at a `capture` strobe. Each clock with `shift` high then moves one bit in on `tdi`, and `tdo` presents the response bit for the same frame index. Bit index 0 is the first bit shifted after the capture. A frame is 125 bits long and the request and response share one index space. The processor can also raise the stall bit on its own through a breakpoint input, so a host that polls with read frames sees the halt.

Top module: `dbg_cpu_ctrl`

## Requirements
- R1: After reset, `cpu_stall`, `cpu_reset` and `tdo` are all 0.
- R2: Index 0 of a frame is a flag bit. Indices 1..4 hold a 4-bit opcode, most significant bit first. Opcode 3 selects a read frame and opcode 4 selects a write frame.
- R3: In a write frame, indices 5..56 carry the 52-bit control field, with index 5 as the reset bit and index 6 as the stall bit. Indices 57..88 carry a CRC-32 over indices 0..56, sent most significant bit first. The CRC starts from all ones, uses polynomial 0x04C11DB7 and shifts left one bit per data bit. On a good frame the register takes the new value at the clock edge of index 88.
- R4: `cpu_reset` is a level. It stays at the last written value until a later good write changes it.
- R5: A write whose CRC does not match changes neither output and returns status 0x1.
- R6: A write whose CRC matches but whose control indices 7..56 are not all zero changes neither output and returns status 0x4.
- R7: In a read frame, indices 5..36 carry a CRC-32 over indices 0..4. The response data region holds the reset bit at index 37 and the stall bit at index 38. Indices 39..88 are zero. If the read CRC does not match, the data region is all zero and the status is 0x1.
- R8: The response carries a 4-bit status at indices 89..92, least significant bit first, with 0 meaning success. It is followed at indices 93..124 by a CRC-32 (same algorithm as R3, most significant bit first) over response indices 37..92. Indices 0..36 read 0, and so does a write frame's data region.
- R9: An opcode other than 3 or 4 (with flag 0) returns status 0x2 and changes nothing.
- R10: A frame whose flag bit is 1 is ignored: no change to the outputs, and `tdo` stays 0 for the whole frame.
- R11: A high `brk` sets `cpu_stall` at the next clock edge. This also holds when a write that clears stall commits on the same edge.
- R12: A frame cut short by a new `capture` before index 88 leaves the register unchanged.
- R13: `tdo` is 0 whenever `sel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | This sub-module is selected by the debug chain |
| capture | input | 1 | Starts a new frame (index 0 next) |
| shift | input | 1 | Shift one frame bit this clock |
| tdi | input | 1 | Serial request bit |
| brk | input | 1 | Processor breakpoint, sets stall |
| tdo | output | 1 | Serial response bit for the current index |
| cpu_stall | output | 1 | Stall request to the processor |
| cpu_reset | output | 1 | Reset request to the processor |

## Verification
The main sweep writes all four combinations of the two live bits and reads each one back. This separates a swapped bit order in the field from a lost bit. Writes that differ from a good one in a single place probe whether a single fault blocks a commit and is reported with the right code: a flipped CRC bit, one reserved bit set at the low, middle and top of the field, or the flag bit set. A sweep over all fourteen other opcodes shows that decode falls through to the error status. Aborted frames, breakpoints that race a commit, and deselection in the middle of a response tell apart a commit that depends on frame position from one that depends on any edge.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  localparam int CRC_W = 32;
  localparam int OP_W  = 4;
  localparam int ST_W  = 4;

  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [OP_W-1:0]  OPC_RD   = 4'h3;
  localparam logic [OP_W-1:0]  OPC_WR   = 4'h4;

  localparam logic [ST_W-1:0] ST_OK  = 4'h0;
  localparam logic [ST_W-1:0] ST_CRC = 4'h1;
  localparam logic [ST_W-1:0] ST_OPC = 4'h2;
  localparam logic [ST_W-1:0] ST_RSV = 4'h4;

  typedef enum logic [2:0] {
    FK_PEND,
    FK_READ,
    FK_WRITE,
    FK_BADOP,
    FK_SKIP
  } frame_kind_t;

  // one serial step of the frame CRC, most significant bit out first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic d);
    return {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{c[CRC_W-1] ^ d}} & CRC_POLY);
  endfunction

  function automatic frame_kind_t decode_kind(input logic flag,
                                              input logic [OP_W-1:0] op);
    if (flag)              return FK_SKIP;
    else if (op == OPC_RD) return FK_READ;
    else if (op == OPC_WR) return FK_WRITE;
    else                   return FK_BADOP;
  endfunction

endpackage

// File: rtl/dcc_frame_rx.sv
module dcc_frame_rx
  import dcc_pkg::*;
#(
  parameter int CTRL_W = 52,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  logic              cur_stall,
  input  logic              cur_reset,
  output logic [CNT_W-1:0]  cnt,
  output frame_kind_t       kind,
  output logic [ST_W-1:0]   stat,
  output logic [1:0]        rd_bits,
  output logic              shift_ev,
  output logic              wr_commit,
  output logic              wr_reset,
  output logic              wr_stall
);

  localparam int HDR_W = 1 + OP_W;
  localparam logic [CNT_W-1:0] I_OP_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] I_F_RST   = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] I_F_STL   = CNT_W'(HDR_W + 1);
  localparam logic [CNT_W-1:0] I_F_LAST  = CNT_W'(HDR_W + CTRL_W - 1);
  localparam logic [CNT_W-1:0] I_RD_END  = CNT_W'(HDR_W + CRC_W - 1);
  localparam logic [CNT_W-1:0] I_WR_END  = CNT_W'(HDR_W + CTRL_W + CRC_W - 1);
  localparam logic [CNT_W-1:0] I_LEN     = CNT_W'(HDR_W + CRC_W + CTRL_W + ST_W + CRC_W);

  logic              cap_ev;
  logic              flag_q;
  logic [OP_W-2:0]   op_sr;
  logic [CRC_W-1:0]  crc_run;
  logic [CRC_W-1:0]  rx_crc;
  logic [CRC_W-1:0]  crc_in;
  logic              crc_match;
  logic              resv_nz;
  logic              in_frame;

  assign cap_ev    = sel & capture;
  assign shift_ev  = sel & shift & ~capture;
  assign in_frame  = shift_ev && (cnt < I_LEN);
  assign crc_in    = {rx_crc[CRC_W-2:0], tdi};
  assign crc_match = (crc_in == crc_run);
  assign wr_commit = in_frame && (kind == FK_WRITE) && (cnt == I_WR_END)
                     && crc_match && !resv_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      kind     <= FK_PEND;
      stat     <= ST_OK;
      rd_bits  <= '0;
      flag_q   <= 1'b0;
      op_sr    <= '0;
      crc_run  <= '1;
      rx_crc   <= '0;
      resv_nz  <= 1'b0;
      wr_reset <= 1'b0;
      wr_stall <= 1'b0;
    end else if (cap_ev) begin
      cnt      <= '0;
      kind     <= FK_PEND;
      stat     <= ST_OK;
      rd_bits  <= '0;
      flag_q   <= 1'b0;
      op_sr    <= '0;
      crc_run  <= '1;
      rx_crc   <= '0;
      resv_nz  <= 1'b0;
      wr_reset <= 1'b0;
      wr_stall <= 1'b0;
    end else if (in_frame) begin
      cnt    <= cnt + 1'b1;
      rx_crc <= crc_in;
      // request CRC covers the header, plus the control field on writes
      if (cnt <= I_OP_LAST || (kind == FK_WRITE && cnt <= I_F_LAST))
        crc_run <= crc_step(crc_run, tdi);
      if (cnt == '0)
        flag_q <= tdi;
      else if (cnt < I_OP_LAST)
        op_sr <= {op_sr[OP_W-3:0], tdi};
      if (cnt == I_OP_LAST) begin
        kind <= decode_kind(flag_q, {op_sr, tdi});
        if (decode_kind(flag_q, {op_sr, tdi}) == FK_BADOP) stat <= ST_OPC;
      end
      if (kind == FK_WRITE) begin
        if (cnt == I_F_RST) wr_reset <= tdi;
        if (cnt == I_F_STL) wr_stall <= tdi;
        if (cnt > I_F_STL && cnt <= I_F_LAST && tdi) resv_nz <= 1'b1;
        if (cnt == I_WR_END)
          stat <= !crc_match ? ST_CRC : (resv_nz ? ST_RSV : ST_OK);
      end
      if (kind == FK_READ && cnt == I_RD_END) begin
        stat    <= crc_match ? ST_OK : ST_CRC;
        rd_bits <= crc_match ? {cur_stall, cur_reset} : 2'b00;
      end
    end
  end

  // a capture always restarts the frame index (R12)
  assert_cnt_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (cnt == '0));

  // the index only moves forward by one per shifted bit (R2)
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && cnt < I_LEN) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/dcc_ctrl_reg.sv
module dcc_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic brk,
  input  logic wr_commit,
  input  logic wr_reset,
  input  logic wr_stall,
  output logic cpu_stall,
  output logic cpu_reset
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_stall <= 1'b0;
      cpu_reset <= 1'b0;
    end else begin
      cpu_stall <= (wr_commit ? wr_stall : cpu_stall) | brk;
      if (wr_commit) cpu_reset <= wr_reset;
    end
  end

  assert_brk_stalls_R11: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> cpu_stall);

  assert_reset_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(cpu_reset));

  assert_stall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> $past(brk || wr_commit));

endmodule

// File: rtl/dcc_resp_tx.sv
module dcc_resp_tx
  import dcc_pkg::*;
#(
  parameter int CTRL_W = 52,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              capture,
  input  logic              shift_ev,
  input  logic [CNT_W-1:0]  cnt,
  input  frame_kind_t       kind,
  input  logic [ST_W-1:0]   stat,
  input  logic [1:0]        rd_bits,
  output logic              tdo
);

  localparam int HDR_W = 1 + OP_W;
  localparam int SI_W  = $clog2(ST_W);
  localparam int CI_W  = $clog2(CRC_W);
  localparam logic [CNT_W-1:0] I_DATA  = CNT_W'(HDR_W + CRC_W);
  localparam logic [CNT_W-1:0] I_DATA1 = CNT_W'(HDR_W + CRC_W + 1);
  localparam logic [CNT_W-1:0] I_STAT  = CNT_W'(HDR_W + CRC_W + CTRL_W);
  localparam logic [CNT_W-1:0] I_OCRC  = CNT_W'(HDR_W + CRC_W + CTRL_W + ST_W);
  localparam logic [CNT_W-1:0] I_LAST  = CNT_W'(HDR_W + CRC_W + CTRL_W + ST_W + CRC_W - 1);

  logic             live;
  logic             bit_c;
  logic             resp_bit;
  logic [CRC_W-1:0] ocrc;

  assign live = (kind == FK_READ) || (kind == FK_WRITE) || (kind == FK_BADOP);

  always_comb begin
    bit_c = 1'b0;
    if (cnt == I_DATA)
      bit_c = (kind == FK_READ) & rd_bits[0];
    else if (cnt == I_DATA1)
      bit_c = (kind == FK_READ) & rd_bits[1];
    else if (cnt >= I_STAT && cnt < I_OCRC)
      bit_c = stat[SI_W'(cnt - I_STAT)];
    else if (cnt >= I_OCRC && cnt <= I_LAST)
      bit_c = ocrc[CI_W'(I_LAST - cnt)];
  end

  assign resp_bit = live & bit_c;
  assign tdo      = sel & resp_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ocrc <= '1;
    else if (sel && capture)
      ocrc <= '1;
    else if (shift_ev && cnt >= I_DATA && cnt < I_OCRC)
      ocrc <= crc_step(ocrc, resp_bit);
  end

endmodule

// File: rtl/dbg_cpu_ctrl.sv
module dbg_cpu_ctrl
  import dcc_pkg::*;
#(
  parameter int CTRL_W = 52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic tdi,
  input  logic brk,
  output logic tdo,
  output logic cpu_stall,
  output logic cpu_reset
);

  localparam int FRAME_LEN = 1 + OP_W + CRC_W + CTRL_W + ST_W + CRC_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic [CNT_W-1:0] cnt;
  frame_kind_t      kind;
  logic [ST_W-1:0]  stat;
  logic [1:0]       rd_bits;
  logic             shift_ev;
  logic             wr_commit;
  logic             wr_reset;
  logic             wr_stall;

  dcc_frame_rx #(.CTRL_W(CTRL_W), .CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .capture   (capture),
    .shift     (shift),
    .tdi       (tdi),
    .cur_stall (cpu_stall),
    .cur_reset (cpu_reset),
    .cnt       (cnt),
    .kind      (kind),
    .stat      (stat),
    .rd_bits   (rd_bits),
    .shift_ev  (shift_ev),
    .wr_commit (wr_commit),
    .wr_reset  (wr_reset),
    .wr_stall  (wr_stall)
  );

  dcc_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .brk       (brk),
    .wr_commit (wr_commit),
    .wr_reset  (wr_reset),
    .wr_stall  (wr_stall),
    .cpu_stall (cpu_stall),
    .cpu_reset (cpu_reset)
  );

  dcc_resp_tx #(.CTRL_W(CTRL_W), .CNT_W(CNT_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .capture  (capture),
    .shift_ev (shift_ev),
    .cnt      (cnt),
    .kind     (kind),
    .stat     (stat),
    .rd_bits  (rd_bits),
    .tdo      (tdo)
  );

  // a committed write always reports success in its status field
  assert_commit_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (stat == ST_OK));

  // reset changes only through a committed write
  assert_reset_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpu_reset) |-> $past(wr_commit));

endmodule

// File: tb/tb_dbg_cpu_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_cpu_ctrl;

  localparam int FL = 125;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, capture = 1'b0, shift = 1'b0;
  logic tdi = 1'b0, brk = 1'b0;
  logic tdo, cpu_stall, cpu_reset;

  int total = 0;
  int bad   = 0;
  logic m_stall = 1'b0, m_reset = 1'b0;

  always #5 clk = ~clk;

  dbg_cpu_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .capture(capture), .shift(shift),
    .tdi(tdi), .brk(brk), .tdo(tdo), .cpu_stall(cpu_stall), .cpu_reset(cpu_reset)
  );

  function automatic logic [31:0] tcrc(input logic [FL-1:0] v, input int lo, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      logic top = c[31];
      c = c << 1;
      if (top != v[lo+i]) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic logic [FL-1:0] put_crc(input logic [FL-1:0] v, input int at,
                                             input logic [31:0] c);
    for (int k = 0; k < 32; k++) v[at+k] = c[31-k];
    return v;
  endfunction

  function automatic logic [FL-1:0] mk_hdr(input logic flag, input logic [3:0] op);
    logic [FL-1:0] v = '0;
    v[0] = flag;
    for (int k = 0; k < 4; k++) v[1+k] = op[3-k];
    return v;
  endfunction

  function automatic logic [FL-1:0] mk_write(input logic flag, input logic r, input logic s,
                                              input logic [49:0] resv, input logic crc_bad);
    logic [FL-1:0] v = mk_hdr(flag, 4'h4);
    logic [31:0] c;
    v[5] = r;
    v[6] = s;
    v[56:7] = resv;
    c = tcrc(v, 0, 57);
    if (crc_bad) c[7] = ~c[7];
    return put_crc(v, 57, c);
  endfunction

  function automatic logic [FL-1:0] mk_read(input logic crc_bad);
    logic [FL-1:0] v = mk_hdr(1'b0, 4'h3);
    logic [31:0] c = tcrc(v, 0, 5);
    if (crc_bad) c[0] = ~c[0];
    return put_crc(v, 5, c);
  endfunction

  function automatic logic [FL-1:0] exp_resp(input logic rd, input logic r, input logic s,
                                              input logic [3:0] st);
    logic [FL-1:0] v = '0;
    v[37] = rd & r;
    v[38] = rd & s;
    for (int k = 0; k < 4; k++) v[89+k] = st[k];
    return put_crc(v, 93, tcrc(v, 37, 56));
  endfunction

  task automatic chk(input string req, input logic [FL-1:0] got, input logic [FL-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, {{(FL-2){1'b0}}, cpu_stall, cpu_reset}, {{(FL-2){1'b0}}, m_stall, m_reset});
  endtask

  task automatic do_frame(input logic [FL-1:0] fin, input int nbits, input int brk_at,
                          output logic [FL-1:0] fout);
    fout = '0;
    @(negedge clk);
    sel = 1'b1; capture = 1'b1; shift = 1'b0;
    @(negedge clk);
    capture = 1'b0; shift = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      tdi = fin[i];
      brk = (i == brk_at);
      #1 fout[i] = tdo;
      @(negedge clk);
    end
    shift = 1'b0; tdi = 1'b0; brk = 1'b0;
  endtask

  task automatic do_read(input string req);
    logic [FL-1:0] r;
    do_frame(mk_read(1'b0), FL, -1, r);
    chk(req, r, exp_resp(1'b1, m_reset, m_stall, 4'h0));
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [FL-1:0] resp;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset outputs", {{(FL-3){1'b0}}, tdo, cpu_stall, cpu_reset}, '0);
    rst_n = 1'b1;

    // R3/R7/R8: sweep all live-bit combinations, write then read back
    for (int p = 0; p < 4; p++) begin
      do_frame(mk_write(1'b0, p[0], p[1], '0, 1'b0), FL, -1, resp);
      chk("R8 write response", resp, exp_resp(1'b0, 1'b0, 1'b0, 4'h0));
      m_reset = p[0]; m_stall = p[1];
      chk_state("R3 write commit");
      do_read("R7 read back");
    end

    // R4: reset level holds through idle time and reads
    do_frame(mk_write(1'b0, 1'b1, 1'b0, '0, 1'b0), FL, -1, resp);
    m_reset = 1'b1; m_stall = 1'b0;
    repeat (20) @(negedge clk);
    chk_state("R4 reset held");
    do_read("R4 reset read");

    // R5: corrupted write CRC
    do_frame(mk_write(1'b0, 1'b0, 1'b1, '0, 1'b1), FL, -1, resp);
    chk("R5 crc status", resp, exp_resp(1'b0, 1'b0, 1'b0, 4'h1));
    chk_state("R5 unchanged");

    // R6: one reserved bit set, low, middle and top of the field
    for (int b = 0; b < 50; b += 24) begin
      logic [49:0] rv = '0;
      rv[b] = 1'b1;
      do_frame(mk_write(1'b0, 1'b0, 1'b1, rv, 1'b0), FL, -1, resp);
      chk("R6 reserved status", resp, exp_resp(1'b0, 1'b0, 1'b0, 4'h4));
      chk_state("R6 unchanged");
    end
    begin
      logic [49:0] rv = '0;
      rv[49] = 1'b1;
      do_frame(mk_write(1'b0, 1'b0, 1'b1, rv, 1'b0), FL, -1, resp);
      chk("R6 reserved top", resp, exp_resp(1'b0, 1'b0, 1'b0, 4'h4));
    end

    // R7: read with bad CRC returns zero data
    do_frame(mk_read(1'b1), FL, -1, resp);
    chk("R7 bad read crc", resp, exp_resp(1'b1, 1'b0, 1'b0, 4'h1));

    // R9: every other opcode
    for (int op = 0; op < 16; op++) begin
      if (op != 3 && op != 4) begin
        logic [FL-1:0] f = mk_hdr(1'b0, op[3:0]);
        f[6:5] = 2'b11;
        do_frame(f, FL, -1, resp);
        chk("R9 bad opcode status", resp, exp_resp(1'b0, 1'b0, 1'b0, 4'h2));
      end
    end
    chk_state("R9 unchanged");

    // R10: flag set, otherwise a well-formed write
    do_frame(mk_write(1'b1, 1'b0, 1'b1, '0, 1'b0), FL, -1, resp);
    chk("R10 skipped frame tdo", resp, '0);
    chk_state("R10 unchanged");

    // R12: abort a write after its control bits but before its CRC end
    do_frame(mk_write(1'b0, 1'b0, 1'b1, '0, 1'b0), 60, -1, resp);
    chk_state("R12 aborted write");
    do_read("R12 read after abort");

    // R11: breakpoint sets stall
    do_frame(mk_write(1'b0, 1'b0, 1'b0, '0, 1'b0), FL, -1, resp);
    m_reset = 1'b0; m_stall = 1'b0;
    @(negedge clk); brk = 1'b1;
    @(negedge clk); brk = 1'b0;
    m_stall = 1'b1;
    chk_state("R11 brk stall");
    do_read("R11 stall visible to read");

    // R11: breakpoint on the same edge as a stall-clearing commit
    do_frame(mk_write(1'b0, 1'b1, 1'b0, '0, 1'b0), FL, 88, resp);
    m_reset = 1'b1; m_stall = 1'b1;
    chk_state("R11 brk beats write");

    // R13: deselect while the stall bit is on tdo
    do_frame(mk_read(1'b0), 38, -1, resp);
    #1 chk("R13 precheck tdo live", {{(FL-1){1'b0}}, tdo}, {{(FL-1){1'b0}}, 1'b1});
    sel = 1'b0;
    #1 chk("R13 tdo quiet", {{(FL-1){1'b0}}, tdo}, '0);
    @(negedge clk);
    sel = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule